// File: doc/BRIEF.md
# Per-Core Interrupt Acknowledge Unit

This unit sits between a core and the enable and routing logic of an interrupt controller. It receives the pending vector already qualified for one core (enabled, unmasked and routed to that core) and answers the core's read of its acknowledge register. The answer is the number of the interrupt the core should service next. If nothing is pending, the answer is a dedicated all-ones code.

Source numbers 0 and 1 are reserved summary lines. Number 0 means that some unmasked inter-core doorbell cause is set. Number 1 means that some unmasked message-signalled doorbell cause is set. Numbers 2 and up are ordinary peripheral sources. When several sources are pending, the lowest number wins, so the two summary lines come before every peripheral. The sources are level-sensitive: software reads repeatedly, services each returned number, and stops when it sees the spurious code. Each read that returns a real number also produces a one-cycle acknowledge pulse that carries that number.

Top module: `iak_unit`

## Requirements
- R1: After reset, the read data holds the spurious code 1023 in bits [9:0], with all other bits zero, and no acknowledge pulse is active.
- R2: A read taken while no pending bit is set returns 1023 in bits [9:0] in the cycle after the strobe, and gives no acknowledge pulse.
- R3: With several pending bits set, a read returns the lowest set index in bits [9:0] in the cycle after the strobe.
- R4: When bit 0 (the inter-core doorbell summary) is pending, a read returns 0, whatever else is pending.
- R5: When bit 1 (the message-signalled doorbell summary) is pending and bit 0 is not, a read returns 1, even while peripheral bits are also set.
- R6: Reads repeated while the pending vector is unchanged return the same number each time. Once that bit is removed, the next read moves on to the next pending source.
- R7: A read that returns a real number raises the acknowledge output for exactly one cycle, in the same cycle as the read data, with the acknowledge id equal to the returned number.
- R8: Without a read strobe, the read data keeps its last value and no acknowledge pulse occurs, even when the pending vector changes.
- R9: Bits [31:10] of the read data are always zero.
- R10: The highest source, NUM_SRC-1, is returned when it is the only pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | NUM_SRC | Qualified pending vector for this core; bit n is source n |
| rd_i | input | 1 | Read strobe of the acknowledge register |
| rdata_o | output | 32 | Read data; the interrupt number is in bits [9:0] |
| ack_o | output | 1 | One-cycle pulse for a read that returned a real number |
| ack_id_o | output | 10 | Number acknowledged by the pulse |

## Verification
The case hardest to produce from the ports is a moving pending vector: bits change between reads, and also while no read is made. This situation shows both that the priority follows the vector at the moment of the strobe and that the output does not follow the vector on its own. The bench changes the vector in the cycles between strobes and checks that the data holds. It then removes the winning bit and reads again to see the selection move on. A final read with the vector empty must return the spurious code.

// File: rtl/iak_pkg.sv
package iak_pkg;
    localparam int ID_W   = 10;
    localparam int DATA_W = 32;
    localparam logic [ID_W-1:0] SPURIOUS_ID = '1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              ack;
        logic [ID_W-1:0]   ack_id;
    } iak_state_t;
endpackage

// File: rtl/iak_pick.sv
module iak_pick
    import iak_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               found_o,
    output logic [ID_W-1:0]    idx_o
);
    // Scan from the top downwards so that the lowest set index is written last and wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                found_o = 1'b1;
                idx_o   = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/iak_word.sv
module iak_word
    import iak_pkg::*;
(
    input  logic              found_i,
    input  logic [ID_W-1:0]   idx_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int PAD_W = DATA_W - ID_W;

    always_comb begin
        word_o = {{PAD_W{1'b0}}, (found_i ? idx_i : SPURIOUS_ID)};
    end
endmodule

// File: rtl/iak_unit.sv
module iak_unit
    import iak_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic               rd_i,
    output logic [31:0]        rdata_o,
    output logic               ack_o,
    output logic [9:0]         ack_id_o
);
    localparam int MIN_SRC = 2;

    initial begin
        if (NUM_SRC < MIN_SRC || NUM_SRC > int'(SPURIOUS_ID))
            $error("iak_unit: NUM_SRC out of range");
    end

    logic              found;
    logic [ID_W-1:0]   idx;
    logic [DATA_W-1:0] word;
    iak_state_t        st_d, st_q;

    iak_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .pend_i  (pend_i),
        .found_o (found),
        .idx_o   (idx)
    );

    iak_word u_word (
        .found_i (found),
        .idx_i   (idx),
        .word_o  (word)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ack    = 1'b0;
        if (rd_i) begin
            st_d.rdata  = word;
            st_d.ack    = found;
            st_d.ack_id = found ? idx : st_q.ack_id;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rdata  <= {{(DATA_W-ID_W){1'b0}}, SPURIOUS_ID};
            st_q.ack    <= 1'b0;
            st_q.ack_id <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o  = st_q.rdata;
    assign ack_o    = st_q.ack;
    assign ack_id_o = st_q.ack_id;

    logic [ID_W-1:0] cur_id;
    assign cur_id = rdata_o[ID_W-1:0];

    a_r7_ack_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(rd_i) && ack_id_o == cur_id && cur_id != SPURIOUS_ID));

    a_r2_spurious_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_i) && $past(pend_i) == '0) |-> (cur_id == SPURIOUS_ID && !ack_o));

    a_r3_lowest_selected: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_i) && cur_id != SPURIOUS_ID) |->
            ((|(($past(pend_i) >> cur_id) & NUM_SRC'(1))) &&
             (($past(pend_i) & ((NUM_SRC'(1) << cur_id) - NUM_SRC'(1))) == '0)));

    a_r8_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_i) |-> ($stable(rdata_o) && !ack_o));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:ID_W] == '0);
endmodule

// File: tb/tb_iak_unit.sv
`timescale 1ns/1ps
module tb_iak_unit;
    localparam int NS = 64;
    localparam int SPUR = 1023;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] pend = '0;
    logic          rd = 1'b0;
    logic [31:0]   rdata;
    logic          ack;
    logic [9:0]    ack_id;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    iak_unit #(.NUM_SRC(NS)) dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .rd_i(rd),
        .rdata_o(rdata), .ack_o(ack), .ack_id_o(ack_id)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe one read and check the data, pulse and id in the following cycle.
    task automatic do_read(string req, int exp);
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        check(req, int'(rdata[9:0]), exp);
        check({req, " upper R9"}, int'(rdata[31:10]), 0);
        check({req, " ack R7"}, int'(ack), (exp != SPUR) ? 1 : 0);
        if (exp != SPUR) check({req, " ack_id R7"}, int'(ack_id), exp);
        @(negedge clk);
        check({req, " pulse width R7"}, int'(ack), 0);
    endtask

    task automatic t_reset;
        check("R1 reset data", int'(rdata), SPUR);
        check("R1 reset ack", int'(ack), 0);
    endtask

    task automatic t_empty;
        pend = '0;
        do_read("R2 empty", SPUR);
    endtask

    task automatic t_lowest;
        pend = '0; pend[40] = 1'b1; pend[7] = 1'b1; pend[12] = 1'b1;
        do_read("R3 lowest of 7/12/40", 7);
        pend = '0; pend[2] = 1'b1; pend[63] = 1'b1;
        do_read("R3 lowest of 2/63", 2);
    endtask

    task automatic t_summary;
        pend = '1;
        do_read("R4 doorbell summary wins", 0);
        pend = '1; pend[0] = 1'b0;
        do_read("R5 message summary", 1);
        pend = '0; pend[0] = 1'b1;
        do_read("R4 doorbell alone", 0);
    endtask

    task automatic t_level;
        pend = '0; pend[9] = 1'b1; pend[30] = 1'b1;
        do_read("R6 first read", 9);
        do_read("R6 repeat read", 9);
        pend[9] = 1'b0;
        do_read("R6 after removal", 30);
        pend[30] = 1'b0;
        do_read("R6 drained", SPUR);
    endtask

    task automatic t_hold;
        pend = '0; pend[21] = 1'b1;
        do_read("R8 setup", 21);
        pend = '0; pend[3] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 hold data", int'(rdata[9:0]), 21);
            check("R8 no ack", int'(ack), 0);
            pend = pend << 1;
        end
    endtask

    task automatic t_top;
        pend = '0; pend[NS-1] = 1'b1;
        do_read("R10 top source", NS - 1);
        pend = '0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_lowest();
        t_summary();
        t_level();
        t_hold();
        t_top();
        t_empty();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule